// File: doc/BRIEF.md
# PCI Bus-Master DMA Start Sequencer

This block opens a bus-master burst on a 32-bit PCI bus and paces its data phases. When the master enable rises, it gives the backend a one-clock start pulse and requests the bus. In that same clock the backend may ask for a hold. While the hold lasts, the address phase is kept off the bus, so the backend gets as long as it needs to fetch its first data word. FRAME# is asserted a fixed two clocks after the hold is released. IRDY# is asserted a fixed two clocks after the backend raises its ready strobe. The backend therefore sets the FRAME#-to-IRDY# spacing itself and still meets the bus limit.

The burst length is sampled with the start pulse. A local word address starts at zero and steps by four bytes on each completed data phase. A take strobe tells the backend that a word has been consumed. FRAME# is withdrawn when the last data phase is presented. After the final phase completes, IRDY# is released and a one-clock done pulse is given.

Top module: `pci_dma_start_seq`

## Requirements
- R1: While `rst_ni` is low, `req_no`, `frame_no` and `irdy_no` are 1, `cbe_no` is 4'hF, `phase_go_o`, `word_take_o` and `burst_done_o` are 0, and `word_addr_o` is 0.
- R2: When the sequencer is idle and `master_en_i` is high at a clock edge after being low at the previous edge, `phase_go_o` is high for exactly the next clock. `req_no` goes low in that same clock.
- R3: `hold_i` is honoured only if it is high at the end of the `phase_go_o` clock and `hold_mode_i` is 0. A hold raised later, or any hold while `hold_mode_i` is 1, has no effect on `frame_no`.
- R4: While an honoured hold is held, `frame_no` stays 1. If `hold_i` is first low in clock t, `frame_no` is 0 from clock t+2. With no honoured hold, `frame_no` is 0 two clocks after the `phase_go_o` clock. Both cases assume the bus is granted.
- R5: `frame_no` falls only in the clock after a clock in which `gnt_ni` was 0 and `devsel_ni` was 1. `req_no` returns to 1 in the same clock that `frame_no` falls. Any grant delay adds clocks to the R4 timing.
- R6: `cbe_no` is 4'h7 (memory write command) in the address phase, 4'h0 (all bytes enabled) in every data phase, and 4'hF when no transaction is in progress.
- R7: `irdy_no` goes low two clocks after the first clock in which `be_strobe_i` is high since `phase_go_o`. It is never low earlier than the clock after the address phase. Once low, it stays low until the final phase completes.
- R8: A data phase completes in a clock in which both `irdy_no` and `trdy_ni` are 0. `word_take_o` is 1 exactly in such clocks, and `word_addr_o` (12 bits, reset to 0 by `phase_go_o`) then advances by 4 on the next clock. In wait states the address holds its value.
- R9: `frame_no` returns to 1 in the clock in which the last data phase is presented, that is, with `irdy_no` low and all but one word done. It never rises while `irdy_no` is 1.
- R10: When the last phase completes, `irdy_no` returns to 1, `cbe_no` returns to 4'hF and `burst_done_o` is 1, all for exactly the following clock. `burst_len_i` is sampled when the burst starts, and a length of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_ni | input | 1 | Bus grant, active low |
| master_en_i | input | 1 | Master enable; a rising edge starts a burst |
| hold_i | input | 1 | Backend request to hold off the address phase |
| hold_mode_i | input | 1 | 0: hold honoured; 1: hold ignored |
| be_strobe_i | input | 1 | Backend ready strobe for the first word |
| trdy_ni | input | 1 | Target ready, active low |
| devsel_ni | input | 1 | Device select, active low; low means the bus is busy |
| burst_len_i | input | LEN_W | Number of words in the burst |
| req_no | output | 1 | Bus request, active low |
| frame_no | output | 1 | FRAME#, active low |
| irdy_no | output | 1 | Initiator ready, active low |
| cbe_no | output | 4 | Command / byte enables |
| phase_go_o | output | 1 | One-clock start pulse to the backend |
| word_addr_o | output | ADDR_W | Local word byte address |
| word_take_o | output | 1 | A word was transferred in this clock |
| burst_done_o | output | 1 | One-clock pulse after the final phase |

## Verification
Bursts are run in several ways:
- No hold, with the strobe raised during the start pulse.
- A long hold followed by a strobe that arrives late.
- A hold raised only after the start clock.
- A hold given while `hold_mode_i` is 1.
- A grant that arrives late while DEVSEL# is busy.

Comparing the no-hold case with the late hold and the mode-1 hold shows that the hold is taken only when it is sampled in the start clock. Comparing the early and late strobes separates the address-phase floor on IRDY# from the exact two-clock strobe latency. Lengths of 0, 1 and several words are combined with TRDY# wait-state patterns, including a wait on the final phase. These show that the address holds during waits, that FRAME# is withdrawn only in the last phase, and that exactly one done pulse is given.

// File: rtl/pci_dms_pkg.sv
package pci_dms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_ARB,
    ST_ADDR,
    ST_DATA
  } dms_state_e;

  localparam logic [3:0] CBE_MEM_WR    = 4'h7;
  localparam logic [3:0] CBE_ALL_BYTES = 4'h0;
  localparam logic [3:0] CBE_PARK      = 4'hF;
endpackage

// File: rtl/dms_launch.sv
module dms_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic idle_i,
  output logic launch_o,
  output logic go_o
);
  logic en_q;

  assign launch_o = en_i & ~en_q & idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      go_o <= 1'b0;
    end else begin
      en_q <= en_i;
      go_o <= launch_o;
    end
  end
endmodule

// File: rtl/dms_strobe_delay.sv
module dms_strobe_delay (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic arm_i,
  input  logic strobe_i,
  output logic ready_o
);
  // sticky flag; together with the registered IRDY# this gives two clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ready_o <= 1'b0;
    else if (clear_i) ready_o <= 1'b0;
    else if (arm_i && strobe_i) ready_o <= 1'b1;
  end
endmodule

// File: rtl/dms_burst_ctr.sv
module dms_burst_ctr #(
  parameter int ADDR_W     = 12,
  parameter int LEN_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              take_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              last_nx_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, len_q, len_m1;

  assign len_m1    = len_q - ONE;
  assign last_o    = (cnt_q == len_m1);
  assign last_nx_o = take_i ? ((cnt_q + ONE) == len_m1) : last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= ONE;
      addr_o <= '0;
    end else if (load_i) begin
      cnt_q  <= '0;
      len_q  <= (len_i == '0) ? ONE : len_i;
      addr_o <= '0;
    end else if (take_i) begin
      cnt_q  <= cnt_q + ONE;
      addr_o <= addr_o + STEP;
    end
  end
endmodule

// File: rtl/pci_dma_start_seq.sv
module pci_dma_start_seq
  import pci_dms_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_ni,
  input  logic              master_en_i,
  input  logic              hold_i,
  input  logic              hold_mode_i,
  input  logic              be_strobe_i,
  input  logic              trdy_ni,
  input  logic              devsel_ni,
  input  logic [LEN_W-1:0]  burst_len_i,
  output logic              req_no,
  output logic              frame_no,
  output logic              irdy_no,
  output logic [3:0]        cbe_no,
  output logic              phase_go_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              word_take_o,
  output logic              burst_done_o
);
  dms_state_e state_q, state_d;
  logic launch, ready, last, last_nx, finish, grant_ok, hold_ok, in_burst;
  logic req_d, frame_d, irdy_d, done_d;
  logic [3:0] cbe_d;

  dms_launch u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (master_en_i),
    .idle_i   (state_q == ST_IDLE),
    .launch_o (launch),
    .go_o     (phase_go_o)
  );

  dms_strobe_delay u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (launch),
    .arm_i    (state_q != ST_IDLE),
    .strobe_i (be_strobe_i),
    .ready_o  (ready)
  );

  dms_burst_ctr #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (launch),
    .len_i     (burst_len_i),
    .take_i    (word_take_o),
    .addr_o    (word_addr_o),
    .last_o    (last),
    .last_nx_o (last_nx)
  );

  assign word_take_o = (state_q == ST_DATA) & ~irdy_no & ~trdy_ni;
  assign finish      = word_take_o & last;
  assign grant_ok    = ~gnt_ni & devsel_ni;
  assign hold_ok     = hold_i & ~hold_mode_i;
  assign in_burst    = (state_q == ST_ADDR) | (state_q == ST_DATA);

  always_comb begin
    if (finish)                irdy_d = 1'b1;
    else if (ready && in_burst) irdy_d = 1'b0;
    else                       irdy_d = irdy_no;
  end

  always_comb begin
    state_d = state_q;
    req_d   = req_no;
    frame_d = frame_no;
    cbe_d   = cbe_no;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_START;
          req_d   = 1'b0;
        end
      end
      ST_START: state_d = hold_ok ? ST_HOLD : ST_ARB;
      ST_HOLD:  if (!hold_i) state_d = ST_ARB;
      ST_ARB: begin
        if (grant_ok) begin
          frame_d = 1'b0;
          req_d   = 1'b1;
          cbe_d   = CBE_MEM_WR;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        state_d = ST_DATA;
        cbe_d   = CBE_ALL_BYTES;
        frame_d = frame_no | (last_nx & ~irdy_d);
      end
      ST_DATA: begin
        if (finish) begin
          frame_d = 1'b1;
          cbe_d   = CBE_PARK;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          frame_d = frame_no | (last_nx & ~irdy_d);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      req_no       <= 1'b1;
      frame_no     <= 1'b1;
      irdy_no      <= 1'b1;
      cbe_no       <= CBE_PARK;
      burst_done_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      req_no       <= req_d;
      frame_no     <= frame_d;
      irdy_no      <= irdy_d;
      cbe_no       <= cbe_d;
      burst_done_o <= done_d;
    end
  end
endmodule

// File: rtl/pci_dma_start_seq_chk.sv
module pci_dma_start_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gnt_ni,
  input logic              master_en_i,
  input logic              hold_i,
  input logic              hold_mode_i,
  input logic              be_strobe_i,
  input logic              trdy_ni,
  input logic              devsel_ni,
  input logic [LEN_W-1:0]  burst_len_i,
  input logic              req_no,
  input logic              frame_no,
  input logic              irdy_no,
  input logic [3:0]        cbe_no,
  input logic              phase_go_o,
  input logic [ADDR_W-1:0] word_addr_o,
  input logic              word_take_o,
  input logic              burst_done_o
);
  assert_go_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_go_o |=> !phase_go_o);

  assert_go_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_go_o) |-> ($past(master_en_i) && !req_no));

  assert_frame_after_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> (req_no && $past(!gnt_ni && devsel_ni)));

  assert_cbe_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irdy_no |-> (cbe_no == 4'h0));

  assert_cbe_park_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_no && irdy_no) |-> (cbe_no == 4'hF));

  assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_take_o |=> (word_addr_o == $past(word_addr_o) + ADDR_W'(4)));

  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_take_o |=> (phase_go_o || $stable(word_addr_o)));

  assert_frame_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |-> !irdy_no);

  assert_done_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> (irdy_no && frame_no && $past(word_take_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |=> !burst_done_o);
endmodule

bind pci_dma_start_seq pci_dma_start_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_pci_dma_start_seq.sv
`timescale 1ns/1ps
module sim_pci_dma_start_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt_n = 1'b1, master_en = 1'b0, hold = 1'b0, hold_mode = 1'b0;
  logic be_strobe = 1'b0, trdy_n = 1'b1, devsel_n = 1'b1;
  logic [7:0] burst_len = 8'd0;
  logic req_no, frame_no, irdy_no, phase_go, word_take, burst_done;
  logic [3:0] cbe_no;
  logic [11:0] word_addr;

  always #10 clk = ~clk;

  pci_dma_start_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .gnt_ni(gnt_n), .master_en_i(master_en),
    .hold_i(hold), .hold_mode_i(hold_mode), .be_strobe_i(be_strobe),
    .trdy_ni(trdy_n), .devsel_ni(devsel_n), .burst_len_i(burst_len),
    .req_no(req_no), .frame_no(frame_no), .irdy_no(irdy_no), .cbe_no(cbe_no),
    .phase_go_o(phase_go), .word_addr_o(word_addr), .word_take_o(word_take),
    .burst_done_o(burst_done)
  );

  int n_checks = 0, n_errs = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle,1 start,2 held,3 waiting grant,4 address,5 data
  int ph = 0, m_cnt = 0, m_len = 1;
  bit m_en_q = 0, m_go = 0, m_req = 1, m_frame = 1, m_irdy = 1, m_done = 0, m_seen = 0;
  logic [3:0] m_cbe = 4'hF;
  logic [11:0] m_addr = 12'd0;
  int mon_ff = -1, mon_if = -1, mon_done = 0;
  bit p_frame = 1, p_irdy = 1;

  always @(posedge clk) begin
    bit take, seen_old;
    cyc++;
    if (!rst_n) begin
      ph = 0; m_en_q = 0; m_go = 0; m_req = 1; m_frame = 1; m_irdy = 1;
      m_done = 0; m_seen = 0; m_cbe = 4'hF; m_addr = 0; m_cnt = 0; m_len = 1;
    end else begin
      take = (ph == 5) && !m_irdy && !trdy_n;
      seen_old = m_seen;
      m_done = 0;
      m_go = 0;
      if (ph != 0 && be_strobe) m_seen = 1;
      case (ph)
        0: if (master_en && !m_en_q) begin
             ph = 1; m_go = 1; m_req = 0; m_cnt = 0; m_addr = 0; m_seen = 0;
             m_len = (burst_len == 0) ? 1 : int'(burst_len);
           end
        1: ph = (hold && !hold_mode) ? 2 : 3;
        2: if (!hold) ph = 3;
        3: if (!gnt_n && devsel_n) begin m_frame = 0; m_req = 1; m_cbe = 4'h7; ph = 4; end
        4: begin
             ph = 5; m_cbe = 4'h0;
             if (seen_old) m_irdy = 0;
             if (m_len == 1 && !m_irdy) m_frame = 1;
           end
        5: begin
             if (take) begin m_cnt++; m_addr = m_addr + 12'd4; end
             if (take && m_cnt == m_len) begin
               m_irdy = 1; m_frame = 1; m_cbe = 4'hF; m_done = 1; ph = 0;
             end else begin
               if (seen_old) m_irdy = 0;
               if (m_cnt == m_len - 1 && !m_irdy) m_frame = 1;
             end
           end
        default: ph = 0;
      endcase
      m_en_q = master_en;
    end
    #5;
    if (rst_n) begin
      chk("R2 phase_go", phase_go, m_go);
      chk("R5 req_no", req_no, m_req);
      chk("R4 frame_no", frame_no, m_frame);
      chk("R7 irdy_no", irdy_no, m_irdy);
      chk("R6 cbe_no", cbe_no, m_cbe);
      chk("R8 word_addr", word_addr, m_addr);
      chk("R8 word_take", word_take, (ph == 5) && !m_irdy && !trdy_n);
      chk("R10 burst_done", burst_done, m_done);
      if (p_frame && !frame_no) mon_ff = cyc;
      if (p_irdy && !irdy_no) mon_if = cyc;
      if (burst_done) mon_done++;
      p_frame = frame_no;
      p_irdy = irdy_no;
    end
  end

  task automatic burst(input int len, input int hold_n, input int stb_at, input int gnt_wait,
                       input bit late, input bit mode, input logic [7:0] pat);
    int t_go, t_rel, t_stb, t_gnt, exp_ff, exp_if, words;
    @(negedge clk);
    master_en = 1; burst_len = 8'(len); hold_mode = mode; gnt_n = (gnt_wait > 0);
    mon_ff = -1; mon_if = -1; mon_done = 0;
    @(negedge clk);
    t_go = cyc; t_rel = cyc; t_gnt = cyc; t_stb = -100;
    chk("R2 go pulse in start clock", phase_go, 1);
    hold = (hold_n > 0);
    be_strobe = (stb_at == 0);
    if (stb_at == 0) t_stb = cyc;
    for (int k = 1; k < 300; k++) begin
      @(negedge clk);
      if (burst_done) break;
      be_strobe = (k == stb_at);
      if (k == stb_at) t_stb = cyc;
      if (hold_n > 0 && k == hold_n) begin
        hold = 0;
        if (!mode) t_rel = cyc;
      end
      if (late) hold = (k >= 1 && k <= 3);
      if (gnt_wait > 0 && k == gnt_wait) begin gnt_n = 0; t_gnt = cyc + 1; end
      devsel_n = !(gnt_wait > 0 && k == gnt_wait);
      trdy_n = pat[k % 8];
    end
    be_strobe = 0; hold = 0; master_en = 0; trdy_n = 1; devsel_n = 1; gnt_n = 1;
    repeat (3) @(negedge clk);
    exp_ff = ((t_gnt > t_rel + 1) ? t_gnt : t_rel + 1) + 1;
    exp_if = (t_stb + 2 > exp_ff + 1) ? t_stb + 2 : exp_ff + 1;
    words = (len == 0) ? 1 : len;
    chk(late || mode ? "R3 ignored hold frame timing" : "R4 frame timing", mon_ff, exp_ff);
    chk("R7 irdy timing", mon_if, exp_if);
    chk("R10 single done pulse", mon_done, 1);
    chk("R8 final address", word_addr, (words * 4) % 4096);
    chk("R9 frame parked after burst", frame_no, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req_no", req_no, 1);
    chk("R1 frame_no", frame_no, 1);
    chk("R1 irdy_no", irdy_no, 1);
    chk("R1 cbe_no", cbe_no, 15);
    chk("R1 go/take/done", {phase_go, word_take, burst_done}, 0);
    chk("R1 word_addr", word_addr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    burst(4, 0, 0, 0, 0, 0, 8'h00);
    burst(3, 6, 9, 0, 0, 0, 8'b0010_0110);
    burst(1, 0, 1, 0, 1, 0, 8'h00);
    burst(2, 4, 0, 0, 0, 1, 8'h00);
    burst(0, 0, 2, 5, 0, 0, 8'b1000_0001);
    burst(5, 2, 3, 0, 0, 0, 8'b0100_1000);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule